// File: doc/BRIEF.md
# Flag-Conditioned Relative Branch Unit

This unit resolves short conditional branches. Each request carries a 4-bit condition code, the four processor status flags, the current 24-bit program counter and a signed 8-bit displacement byte from the instruction stream. The unit decides whether the branch is taken and produces the next program counter. The program counter at its input already points past the branch instruction.

The displacement counts 16-bit words. It is sign-extended, doubled and added to the program counter. The sum wraps modulo 2^24 and its lowest bit is cleared, so a taken branch always lands on an even address. When the branch is not taken, the incoming program counter is passed on unchanged. By default the result is registered and appears one clock after the request. A parameter can select a purely combinational variant instead.

Top module: `branch_unit`

## Requirements
- R1: While reset is asserted, and after it is released until the first request, `res_valid`, `res_taken` and `res_pc` are all zero.
- R2: A request presented with `req_valid` high at a rising clock edge produces its result on the outputs after that edge, with `res_valid` high. `res_valid` is low after any edge where `req_valid` was low.
- R3: A taken branch yields `res_pc` = (`req_pc` + sign_extend(`req_disp`) * 2) mod 2^24 with bit 0 forced to 0. Backward displacements (0x80..0xFF) wrap below zero, and forward sums wrap above 0xFFFFFF.
- R4: Condition code 0 (always) is taken whatever the flags are.
- R5: Code 1 (carry clear) is taken when `req_flags[0]` (carry) is 0. Code 2 (carry set) is taken when it is 1.
- R6: Code 3 (equal) is taken when `req_flags[1]` (zero) is 1. Code 4 (not equal) is taken when it is 0.
- R7: Code 5 (minus) is taken when `req_flags[2]` (negative) is 1. Code 6 (plus) is taken when it is 0.
- R8: Code 7 (overflow) is taken when `req_flags[3]` (overflow) is 1. Code 8 (no overflow) is taken when it is 0.
- R9: Codes 9 through 15 are never taken, for any flags.
- R10: A branch that is not taken gives `res_pc` equal to `req_pc` exactly, including an odd value.
- R11: While `req_valid` is low, `res_taken` and `res_pc` keep the values from the last request, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_cond | input | 4 | Condition code (0 always, 1..8 flag tests, 9..15 never) |
| req_flags | input | 4 | Status flags: bit0 carry, bit1 zero, bit2 negative, bit3 overflow |
| req_pc | input | 24 | Program counter after the branch instruction |
| req_disp | input | 8 | Signed displacement in 16-bit words |
| res_valid | output | 1 | Result valid |
| res_taken | output | 1 | Branch taken |
| res_pc | output | 24 | Next program counter |

## Verification
The assertions check several properties on every cycle:
- the one-cycle valid pipeline;
- the even alignment of every taken target;
- the fixed outcome of the always code and the unused codes;
- the carry-set decision;
- exact pass-through of the program counter when the branch is not taken;
- holding of the outputs while no request is present.

Only the bench's scenarios can show that the sums are arithmetically correct, since that needs an independent model. This covers backward wrap below address zero, forward wrap past the top of the space, and the full condition-by-flag matrix. Held-output behaviour under changing idle inputs is likewise shown by a directed scenario.

// File: rtl/branch_unit_pkg.sv
package branch_unit_pkg;
   localparam int FLAG_C = 0;
   localparam int FLAG_Z = 1;
   localparam int FLAG_N = 2;
   localparam int FLAG_V = 3;

   typedef enum logic [3:0] {
      COND_ALWAYS   = 4'd0,
      COND_CARRY_LO = 4'd1,
      COND_CARRY_HI = 4'd2,
      COND_EQUAL    = 4'd3,
      COND_UNEQUAL  = 4'd4,
      COND_MINUS    = 4'd5,
      COND_PLUS     = 4'd6,
      COND_OVFL     = 4'd7,
      COND_NO_OVFL  = 4'd8
   } cond_code_t;
endpackage

// File: rtl/branch_cond_eval.sv
module branch_cond_eval
   import branch_unit_pkg::*;
#(
   parameter int SEL_W  = 4,
   parameter int FLAG_W = 4
) (
   input  logic [SEL_W-1:0]  sel,
   input  logic [FLAG_W-1:0] flags,
   output logic              taken
);
   initial begin
      if (SEL_W != 4)  $error("branch_cond_eval: SEL_W must be 4");
      if (FLAG_W != 4) $error("branch_cond_eval: FLAG_W must be 4");
   end

   always_comb begin
      case (sel)
         COND_ALWAYS:   taken = 1'b1;
         COND_CARRY_LO: taken = ~flags[FLAG_C];
         COND_CARRY_HI: taken =  flags[FLAG_C];
         COND_EQUAL:    taken =  flags[FLAG_Z];
         COND_UNEQUAL:  taken = ~flags[FLAG_Z];
         COND_MINUS:    taken =  flags[FLAG_N];
         COND_PLUS:     taken = ~flags[FLAG_N];
         COND_OVFL:     taken =  flags[FLAG_V];
         COND_NO_OVFL:  taken = ~flags[FLAG_V];
         default:       taken = 1'b0;
      endcase
   end
endmodule

// File: rtl/branch_target_calc.sv
module branch_target_calc #(
   parameter int PC_W        = 24,
   parameter int DISP_W      = 8,
   parameter int SCALE_SHIFT = 1,
   parameter int ALIGN_BITS  = 1
) (
   input  logic [PC_W-1:0]   pc,
   input  logic [DISP_W-1:0] disp,
   output logic [PC_W-1:0]   target
);
   localparam int EXT_W = PC_W - DISP_W;

   initial begin
      if (PC_W <= DISP_W + SCALE_SHIFT)
         $error("branch_target_calc: PC_W too small for scaled displacement");
      if (ALIGN_BITS < 0 || ALIGN_BITS >= PC_W)
         $error("branch_target_calc: ALIGN_BITS out of range");
   end

   logic [PC_W-1:0] disp_ext;
   logic [PC_W-1:0] disp_scaled;
   logic [PC_W-1:0] sum;
   logic [PC_W-1:0] align_mask;

   assign disp_ext    = {{EXT_W{disp[DISP_W-1]}}, disp};
   assign disp_scaled = disp_ext << SCALE_SHIFT;
   assign sum         = pc + disp_scaled;
   assign align_mask  = {PC_W{1'b1}} << ALIGN_BITS;
   assign target      = sum & align_mask;
endmodule

// File: rtl/branch_unit.sv
module branch_unit #(
   parameter int PC_W        = 24,
   parameter int DISP_W      = 8,
   parameter int SEL_W       = 4,
   parameter int FLAG_W      = 4,
   parameter int SCALE_SHIFT = 1,
   parameter int ALIGN_BITS  = 1,
   parameter bit REG_OUT     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [SEL_W-1:0]  req_cond,
   input  logic [FLAG_W-1:0] req_flags,
   input  logic [PC_W-1:0]   req_pc,
   input  logic [DISP_W-1:0] req_disp,
   output logic              res_valid,
   output logic              res_taken,
   output logic [PC_W-1:0]   res_pc
);
   logic            cond_hit;
   logic [PC_W-1:0] tgt_pc;
   logic [PC_W-1:0] nxt_pc;

   branch_cond_eval #(.SEL_W(SEL_W), .FLAG_W(FLAG_W)) u_cond (
      .sel   (req_cond),
      .flags (req_flags),
      .taken (cond_hit)
   );

   branch_target_calc #(
      .PC_W(PC_W), .DISP_W(DISP_W),
      .SCALE_SHIFT(SCALE_SHIFT), .ALIGN_BITS(ALIGN_BITS)
   ) u_tgt (
      .pc     (req_pc),
      .disp   (req_disp),
      .target (tgt_pc)
   );

   assign nxt_pc = cond_hit ? tgt_pc : req_pc;

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               res_valid <= 1'b0;
               res_taken <= 1'b0;
               res_pc    <= '0;
            end else begin
               res_valid <= req_valid;
               if (req_valid) begin
                  res_taken <= cond_hit;
                  res_pc    <= nxt_pc;
               end
            end
         end
      end else begin : g_comb
         assign res_valid = req_valid;
         assign res_taken = req_valid & cond_hit;
         assign res_pc    = nxt_pc;
      end
   endgenerate
endmodule

// File: rtl/branch_unit_chk.sv
module branch_unit_chk #(
   parameter int PC_W    = 24,
   parameter int DISP_W  = 8,
   parameter int SEL_W   = 4,
   parameter int FLAG_W  = 4,
   parameter bit REG_OUT = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [SEL_W-1:0]  req_cond,
   input logic [FLAG_W-1:0] req_flags,
   input logic [PC_W-1:0]   req_pc,
   input logic              res_valid,
   input logic              res_taken,
   input logic [PC_W-1:0]   res_pc
);
   generate
      if (REG_OUT) begin : g_props
         // R2
         assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
            req_valid |=> res_valid);
         // R2
         assert_idle_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
            !req_valid |=> !res_valid);
         // R3
         assert_even_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (res_valid && res_taken) |-> (res_pc[0] == 1'b0));
         // R4
         assert_always_taken_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && req_cond == 4'd0) |=> res_taken);
         // R5
         assert_carry_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && req_cond == 4'd2 && req_flags[0]) |=> res_taken);
         // R9
         assert_unused_never_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && req_cond >= 4'd9) |=> !res_taken);
         // R10
         assert_pass_through_R10: assert property (@(posedge clk) disable iff (!rst_n)
            req_valid |=> (res_taken || res_pc == $past(req_pc)));
         // R11
         assert_hold_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
            (!req_valid && !$past(!rst_n)) |=> ($stable(res_pc) && $stable(res_taken)));
      end
   endgenerate
endmodule

bind branch_unit branch_unit_chk #(
   .PC_W(PC_W), .DISP_W(DISP_W), .SEL_W(SEL_W), .FLAG_W(FLAG_W), .REG_OUT(REG_OUT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_cond  (req_cond),
   .req_flags (req_flags),
   .req_pc    (req_pc),
   .res_valid (res_valid),
   .res_taken (res_taken),
   .res_pc    (res_pc)
);

// File: tb/branch_unit_bench.sv
`timescale 1ns/1ps
module branch_unit_bench;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid;
   logic [3:0]  req_cond;
   logic [3:0]  req_flags;
   logic [23:0] req_pc;
   logic [7:0]  req_disp;
   logic        res_valid;
   logic        res_taken;
   logic [23:0] res_pc;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   branch_unit u_branch_unit (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
      .req_cond(req_cond), .req_flags(req_flags),
      .req_pc(req_pc), .req_disp(req_disp),
      .res_valid(res_valid), .res_taken(res_taken), .res_pc(res_pc)
   );

   function automatic bit model_taken(input logic [3:0] c, input logic [3:0] f);
      case (c)
         4'd0: return 1'b1;
         4'd1: return !f[0];
         4'd2: return  f[0];
         4'd3: return  f[1];
         4'd4: return !f[1];
         4'd5: return  f[2];
         4'd6: return !f[2];
         4'd7: return  f[3];
         4'd8: return !f[3];
         default: return 1'b0;
      endcase
   endfunction

   function automatic logic [23:0] model_pc(input logic [3:0] c, input logic [3:0] f,
                                            input logic [23:0] pc, input logic [7:0] d);
      int signed off;
      logic [23:0] t;
      if (!model_taken(c, f)) return pc;
      off = $signed(d) * 2;
      t = pc + off[23:0];
      t[0] = 1'b0;
      return t;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic issue(input string req, input logic [3:0] c, input logic [3:0] f,
                        input logic [23:0] pc, input logic [7:0] d);
      req_valid = 1'b1; req_cond = c; req_flags = f; req_pc = pc; req_disp = d;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      check({req, " valid"}, {31'd0, res_valid}, 32'd1);
      check({req, " taken"}, {31'd0, res_taken}, {31'd0, model_taken(c, f)});
      check({req, " pc"}, {8'd0, res_pc}, {8'd0, model_pc(c, f, pc, d)});
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int unsigned seed;
      logic [23:0] held_pc;
      logic        held_tk;
      void'($urandom(32'd1234));
      rst_n = 1'b0; req_valid = 1'b0; req_cond = '0; req_flags = '0;
      req_pc = '0; req_disp = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 reset valid", {31'd0, res_valid}, 32'd0);
      check("R1 reset taken", {31'd0, res_taken}, 32'd0);
      check("R1 reset pc", {8'd0, res_pc}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release pc", {8'd0, res_pc}, 32'd0);

      issue("R4 always", 4'd0, 4'hF, 24'h001000, 8'h10);
      issue("R3 backward wrap", 4'd0, 4'h0, 24'h000000, 8'h80);
      issue("R3 forward wrap", 4'd0, 4'h0, 24'hFFFFFE, 8'h01);
      issue("R3 odd pc aligned", 4'd0, 4'h0, 24'h000101, 8'h00);
      issue("R10 odd pc pass", 4'd9, 4'hF, 24'h000101, 8'h05);
      for (int c = 1; c <= 8; c++)
         for (int f = 0; f < 16; f++)
            issue((c <= 2) ? "R5 carry" : (c <= 4) ? "R6 zero" :
                  (c <= 6) ? "R7 neg" : "R8 ovfl",
                  c[3:0], f[3:0], 24'h123456, 8'hFE);
      for (int c = 9; c < 16; c++)
         issue("R9 unused", c[3:0], 4'hF, 24'h00ABCD, 8'h7F);

      @(negedge clk);
      check("R2 idle valid", {31'd0, res_valid}, 32'd0);
      issue("R2 one cycle", 4'd3, 4'h2, 24'h400000, 8'h40);
      held_pc = res_pc; held_tk = res_taken;
      req_cond = 4'd0; req_pc = 24'h777777; req_disp = 8'h33;
      repeat (3) @(negedge clk);
      check("R11 hold pc", {8'd0, res_pc}, {8'd0, held_pc});
      check("R11 hold taken", {31'd0, res_taken}, {31'd0, held_tk});
      check("R2 no valid when idle", {31'd0, res_valid}, 32'd0);

      for (int i = 0; i < 400; i++) begin
         seed = $urandom;
         issue("R3 random", seed[3:0], seed[7:4], $urandom, seed[15:8]);
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule